// File: doc/BRIEF.md
# Per-Lane Read Offset Calibration Engine

This block is a hardware sequencer that trains the read-strobe offset of a 32-bit memory channel built from four byte lanes. On a full calibration it first stores a fixed four-word test pattern in memory. It then sweeps a signed offset for each lane, first upward from a left limit and then downward from a right limit. For each sweep it records the first shift at which that lane's byte of all four words reads back intact. Finally it programs, for every lane, the midpoint of the two recorded shifts.

The offset word is one 32-bit value with four signed fields in sign-magnitude form. Every time a new word is presented on the offset output, a resync strobe follows so the delay lines pick it up. The search window is set by a coarse lock value taken from the PHY. On a resume from a low-power state, the engine does not sweep. It re-applies a 32-bit word that was saved after an earlier calibration, and it presents the freshly calibrated word on a save port so that it can be kept for that purpose.

The memory port is a single-request handshake: one request cycle, then the engine waits for an acknowledge, which also carries the read data. The memory itself and the delay lines are outside the block.

Top module: `rd_offset_cal`

## Requirements
- R1: After reset, offset_word is 0x08080808, and busy, done, offset_wr, resync, save_valid and mem_req are all low. While idle, no memory request and no offset write is issued.
- R2: Lane n of offset_word occupies bits [8n+7:8n]. A lane value v in -127..+127 is encoded as v when v >= 0 and as 0x80 OR |v| when v < 0. The code 0x80 is never produced.
- R3: A full calibration starts with four memory writes at byte addresses BASE_ADDR + 0x80*chan + 4k, k = 0..3, with data 0x5A5A5A5A, 0xA5A5A5A5, 0xF0F0F0F0 and 0x0F0F0F0F in that order. No read is issued before the fourth write is acknowledged.
- R4: The sweep limits are L = max(8 - lock_coarse, -127) and R = min(8 + lock_coarse, 127), sampled at start.
- R5: For each lane, the first sweep tests L, L+1, ... up to R, and the second sweep tests R, R-1, ... down to L. Each sweep stops at the first passing shift. A shift passes when the lane's byte of all four pattern words reads back correctly. During a lane's sweep every other lane field holds 8.
- R6: A sweep that finds no passing shift leaves that lane's result at 8.
- R7: Each offset write is a one-cycle offset_wr pulse. It is followed in the very next cycle by a one-cycle resync pulse. No memory request is issued during either pulse.
- R8: The final word sets every lane to (left + right) / 2, truncated toward zero and encoded as in R2, in a single write. done pulses for one cycle after that write's resync.
- R9: On the done cycle of a full calibration, save_valid is high and save_word equals the final offset word.
- R10: A start with resume high applies saved_word with a single write and resync, issues no memory access, and raises done without save_valid.
- R11: A full calibration performs exactly one default write per lane and sweep, one write per shift tested, and one final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| resume | input | 1 | Sampled with start: 1 restores saved_word, 0 calibrates |
| chan | input | CH_W | Channel index, selects the 0x80-byte pattern region |
| lock_coarse | input | LOCK_W | Coarse lock value that sets the sweep limits |
| saved_word | input | 32 | Previously saved offset word used on resume |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| offset_word | output | 32 | Four sign-magnitude lane offsets |
| offset_wr | output | 1 | offset_word has just been updated |
| resync | output | 1 | Resync strobe, the cycle after offset_wr |
| save_word | output | 32 | Word to keep for a later resume |
| save_valid | output | 1 | save_word is a fresh calibration result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The checker watches, on every cycle, how offset writes and resync strobes relate to each other. It checks that no memory request overlaps them, that done is a single cycle following a resync, that the idle state stays quiet, and that the negative-zero code never appears on any lane. Where each sweep stops, how the limits are clamped, the truncation of the midpoint, the pattern addresses for each channel, the number of writes and the resume path can only be shown by the bench. Its memory model corrupts a lane's byte whenever that lane's applied offset lies outside a chosen window, and it compares the outcome with values computed from the windows and lock values.

// File: rtl/rd_offset_cal.sv
module rd_offset_cal #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000,
  parameter int CH_W = 1,
  parameter int LOCK_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resume,
  input  logic [CH_W-1:0]   chan,
  input  logic [LOCK_W-1:0] lock_coarse,
  input  logic [31:0]       saved_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       offset_word,
  output logic              offset_wr,
  output logic              resync,
  output logic [31:0]       save_word,
  output logic              save_valid,
  output logic              busy,
  output logic              done
);
  localparam int LANES = 4;
  localparam logic signed [9:0] DEF = 10'sd8;
  localparam logic [31:0] DEF_WORD = {LANES{8'h08}};

  typedef enum logic [3:0] {
    S_IDLE, S_PAT, S_PATW, S_LANE, S_SHIFT, S_RD, S_RDW,
    S_NEXT, S_CENT, S_WR, S_RSY, S_FIN
  } st_t;

  st_t st, ret;
  logic [1:0] k, lane;
  logic dir, resumed;
  logic [LOCK_W-1:0] lock_q;
  logic [CH_W-1:0] chan_q;
  logic signed [9:0] lock_s, raw_l, raw_r, lim_l, lim_r, shift, stop_at;
  logic signed [9:0] res_l [LANES];
  logic signed [9:0] res_r [LANES];
  logic [31:0] offset_q, cen_word, pat_k;
  logic hit;

  function automatic logic [31:0] pat(input logic [1:0] i);
    case (i)
      2'd0: return 32'h5A5A5A5A;
      2'd1: return 32'hA5A5A5A5;
      2'd2: return 32'hF0F0F0F0;
      default: return 32'h0F0F0F0F;
    endcase
  endfunction

  function automatic logic [7:0] sm8(input logic signed [9:0] v);
    logic signed [9:0] m;
    m = -v;
    return (v < 0) ? {1'b1, m[6:0]} : {1'b0, v[6:0]};
  endfunction

  function automatic logic [7:0] mid8(input logic signed [9:0] a, input logic signed [9:0] b);
    logic signed [9:0] s, h;
    s = a + b;
    h = s[9] ? -((-s) >>> 1) : (s >>> 1);
    return sm8(h);
  endfunction

  assign lock_s  = 10'(lock_q);
  assign raw_l   = DEF - lock_s;
  assign raw_r   = DEF + lock_s;
  assign lim_l   = (raw_l < -10'sd127) ? -10'sd127 : raw_l;
  assign lim_r   = (raw_r > 10'sd127) ? 10'sd127 : raw_r;
  assign stop_at = dir ? lim_l : lim_r;
  assign pat_k   = pat(k);
  assign hit     = mem_rdata[8*lane +: 8] == pat_k[8*lane +: 8];

  always_comb begin
    cen_word = '0;
    for (int i = 0; i < LANES; i++) cen_word[8*i +: 8] = mid8(res_l[i], res_r[i]);
  end

  assign mem_req     = (st == S_PAT) || (st == S_RD);
  assign mem_we      = (st == S_PAT);
  assign mem_addr    = BASE_ADDR + (ADDR_W'(chan_q) << 7) + (ADDR_W'(k) << 2);
  assign mem_wdata   = pat_k;
  assign offset_word = offset_q;
  assign save_word   = offset_q;
  assign offset_wr   = (st == S_WR);
  assign resync      = (st == S_RSY);
  assign done        = (st == S_FIN);
  assign save_valid  = done && !resumed;
  assign busy        = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ret <= S_IDLE;
      k <= '0;
      lane <= '0;
      dir <= 1'b0;
      resumed <= 1'b0;
      lock_q <= '0;
      chan_q <= '0;
      shift <= '0;
      offset_q <= DEF_WORD;
      for (int i = 0; i < LANES; i++) begin
        res_l[i] <= DEF;
        res_r[i] <= DEF;
      end
    end else begin
      case (st)
        S_IDLE: if (start) begin
          resumed <= resume;
          lock_q <= lock_coarse;
          chan_q <= chan;
          k <= '0;
          if (resume) begin
            offset_q <= saved_word;
            ret <= S_FIN;
            st <= S_WR;
          end else begin
            st <= S_PAT;
          end
        end
        S_PAT: st <= S_PATW;
        S_PATW: if (mem_ack) begin
          if (k == 2'd3) begin
            lane <= '0;
            dir <= 1'b0;
            st <= S_LANE;
          end else begin
            k <= k + 2'd1;
            st <= S_PAT;
          end
        end
        S_LANE: begin
          offset_q <= DEF_WORD;
          if (dir) res_r[lane] <= DEF;
          else     res_l[lane] <= DEF;
          shift <= dir ? lim_r : lim_l;
          ret <= S_SHIFT;
          st <= S_WR;
        end
        S_SHIFT: begin
          offset_q[8*lane +: 8] <= sm8(shift);
          k <= '0;
          ret <= S_RD;
          st <= S_WR;
        end
        S_RD: st <= S_RDW;
        S_RDW: if (mem_ack) begin
          if (!hit) begin
            if (shift == stop_at) st <= S_NEXT;
            else begin
              shift <= dir ? shift - 10'sd1 : shift + 10'sd1;
              st <= S_SHIFT;
            end
          end else if (k == 2'd3) begin
            if (dir) res_r[lane] <= shift;
            else     res_l[lane] <= shift;
            st <= S_NEXT;
          end else begin
            k <= k + 2'd1;
            st <= S_RD;
          end
        end
        S_NEXT: begin
          lane <= lane + 2'd1;
          if (lane == 2'd3) begin
            if (dir) st <= S_CENT;
            else begin
              dir <= 1'b1;
              st <= S_LANE;
            end
          end else st <= S_LANE;
        end
        S_CENT: begin
          offset_q <= cen_word;
          ret <= S_FIN;
          st <= S_WR;
        end
        S_WR:  st <= S_RSY;
        S_RSY: st <= ret;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rd_offset_cal_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        offset_wr,
  input logic        resync,
  input logic        done,
  input logic        busy,
  input logic [31:0] offset_word
);
  // R7
  wr_then_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_wr |=> resync);
  // R7
  resync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);
  // R7
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_wr || resync) |-> !mem_req);
  // R8
  done_after_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(resync));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !offset_wr));
  // R2
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_word[7:0] != 8'h80) && (offset_word[15:8] != 8'h80) &&
    (offset_word[23:16] != 8'h80) && (offset_word[31:24] != 8'h80));
endmodule

bind rd_offset_cal rd_offset_cal_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .offset_wr(offset_wr),
  .resync(resync), .done(done), .busy(busy), .offset_word(offset_word)
);

// File: tb/sim_rd_offset_cal.sv
module sim_rd_offset_cal;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, resume = 1'b0;
  logic [0:0] chan = '0;
  logic [6:0] lock_coarse = '0;
  logic [31:0] saved_word = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [31:0] offset_word, save_word;
  logic offset_wr, resync, save_valid, busy, done;

  always #5 clk = ~clk;

  rd_offset_cal u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .chan(chan),
    .lock_coarse(lock_coarse), .saved_word(saved_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .offset_word(offset_word), .offset_wr(offset_wr), .resync(resync),
    .save_word(save_word), .save_valid(save_valid), .busy(busy), .done(done)
  );

  int vectors = 0, fails = 0;
  int lo [4], hi [4];
  logic [31:0] mem [64];
  logic pend = 1'b0, pwe = 1'b0, prev_wr = 1'b0;
  logic [31:0] paddr = '0;
  int applies, seq_err, multi, n_wr, n_rd, rd_early, wr_bad;

  function automatic int dec(input logic [7:0] f);
    return f[7] ? -int'(f[6:0]) : int'(f[6:0]);
  endfunction

  function automatic logic [31:0] patw(input int i);
    case (i)
      0: return 32'h5A5A5A5A;
      1: return 32'hA5A5A5A5;
      2: return 32'hF0F0F0F0;
      default: return 32'h0F0F0F0F;
    endcase
  endfunction

  always @(negedge clk) begin
    mem_ack = pend;
    if (pend && !pwe) begin
      logic [31:0] d;
      d = mem[(paddr - BASE) >> 2];
      for (int n = 0; n < 4; n++) begin
        int v;
        v = dec(offset_word[8*n +: 8]);
        if (v < lo[n] || v > hi[n]) d[8*n +: 8] = ~d[8*n +: 8];
      end
      mem_rdata = d;
    end
    pend = mem_req;
    if (mem_req) begin
      paddr = mem_addr;
      pwe = mem_we;
      if (mem_we) begin
        if (mem_addr != BASE + 32'(chan) * 128 + 32'(n_wr) * 4 || mem_wdata != patw(n_wr))
          wr_bad++;
        mem[(mem_addr - BASE) >> 2] = mem_wdata;
        n_wr++;
      end else begin
        if (n_wr < 4) rd_early++;
        n_rd++;
      end
    end
    if (offset_wr) begin
      int c;
      applies++;
      c = 0;
      for (int n = 0; n < 4; n++) if (offset_word[8*n +: 8] != 8'h08) c++;
      if (c > 1) multi++;
    end
    if (prev_wr != resync) seq_err++;
    prev_wr = offset_wr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_run(input int lock, output logic [31:0] word, output int napp);
    int L, R;
    L = 8 - lock; if (L < -127) L = -127;
    R = 8 + lock; if (R > 127) R = 127;
    word = '0;
    napp = 1;
    for (int n = 0; n < 4; n++) begin
      int a, b, l, r, c;
      bit found;
      a = (lo[n] > L) ? lo[n] : L;
      b = (hi[n] < R) ? hi[n] : R;
      found = (a <= b);
      l = found ? a : 8;
      r = found ? b : 8;
      napp += 2 + (found ? (l - L + 1) : (R - L + 1)) + (found ? (R - r + 1) : (R - L + 1));
      c = (l + r) / 2;
      word[8*n +: 8] = (c < 0) ? (8'h80 | 8'(-c)) : 8'(c);
    end
  endtask

  task automatic go(input bit res, input int ch, input int lock, input logic [31:0] sv);
    int wd;
    applies = 0; seq_err = 0; multi = 0; n_wr = 0; n_rd = 0; rd_early = 0; wr_bad = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    resume = res; chan = 1'(ch); lock_coarse = 7'(lock); saved_word = sv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wd = 0;
    while (!done && wd < 40000) begin
      @(negedge clk);
      wd++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog R8 actual=no_done expected=done");
    end
  endtask

  task automatic calib(input int ch, input int lock);
    logic [31:0] w;
    int na;
    expect_run(lock, w, na);
    go(1'b0, ch, lock, '0);
    chk($sformatf("R2 R4 R5 R6 R8 final word lock=%0d", lock), offset_word, w);
    chk("R9 save_valid", 32'(save_valid), 32'd1);
    chk("R9 save_word", save_word, w);
    chk("R11 apply count", 32'(applies), 32'(na));
    chk("R7 write/resync pairing", 32'(seq_err), 32'd0);
    chk("R5 other lanes held at 8", 32'(multi <= 1), 32'd1);
    chk("R3 pattern writes", {16'(n_wr), 16'(wr_bad + rd_early)}, {16'd4, 16'd0});
    @(negedge clk);
    chk("R8 done single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic set_win(input int l0, h0, l1, h1, l2, h2, l3, h3);
    lo[0] = l0; hi[0] = h0; lo[1] = l1; hi[1] = h1;
    lo[2] = l2; hi[2] = h2; lo[3] = l3; hi[3] = h3;
  endtask

  initial begin
    int locks [4];
    locks = '{0, 3, 20, 127};
    set_win(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 reset offset", offset_word, 32'h08080808);
    chk("R1 reset flags", {26'd0, busy, done, offset_wr, resync, save_valid, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle quiet", {29'd0, busy, mem_req, offset_wr}, 32'd0);

    for (int cfg = 0; cfg < 3; cfg++) begin
      case (cfg)
        0: set_win(-3, 12, 0, 0, 5, 20, 9, 8);
        1: set_win(-12, -1, -12, -2, 100, 127, -127, 127);
        default: set_win(8, 8, -50, 60, 3, 3, -7, -7);
      endcase
      foreach (locks[j]) calib(0, locks[j]);
    end

    set_win(-5, 11, 2, 30, -20, -9, 8, 8);
    calib(1, 25);

    go(1'b1, 0, 9, 32'h85_7F_00_FF);
    chk("R10 restored word", offset_word, 32'h85_7F_00_FF);
    chk("R10 no save_valid", 32'(save_valid), 32'd0);
    chk("R10 single apply", 32'(applies), 32'd1);
    chk("R10 no memory access", 32'(n_wr + n_rd), 32'd0);
    chk("R7 resume resync", 32'(seq_err), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule